// File: doc/BRIEF.md
# Programmable-Length Up/Down Loop Counter

This block is the loop filter of an all-digital phase-locked loop. It is a binary counter that moves up or down by one on each rising clock edge, and the phase detector output selects the direction. A 4-bit length code sets the counter length to a power of two between 8 and 131072. The all-zero code stops the counter. When the count passes the top of its current range while counting up, the block emits a one-cycle carry pulse. When it passes below zero while counting down, it emits a one-cycle borrow pulse. A downstream stage adds or removes output pulses in response to these two pulses.

The length code may change while the loop runs, which changes the loop bandwidth in real time. The count register is always 17 bits wide. Only the low bits selected by the current code take part in counting and wrap detection, so after the length shrinks, the next wrap happens within one period of the new length.

Top module: `modloop_counter`

## Requirements
- R1: A high `rst` at a rising clock edge sets the count to zero and drives `carryPulse` and `borrowPulse` low after that edge.
- R2: While `modSel` is 0, the counter does not count and emits no pulses. When counting resumes, it continues from the count it held before.
- R3: For `modSel` = n with n from 1 to 15, the counter length is 2^(n+2). Counting up from zero, the carry pulse follows the 2^(n+2)-th enabled edge.
- R4: `dirDown` = 0 makes the counter count up and `dirDown` = 1 makes it count down, checked at each edge.
- R5: An enabled up-count edge whose masked count equals all ones for the current length sets the count to zero. `carryPulse` is high for the following clock cycle.
- R6: An enabled down-count edge whose masked count is zero sets the count to all ones for the current length. `borrowPulse` is high for the following clock cycle.
- R7: While `cntEn` is low, the count holds and no pulse is emitted.
- R8: Each carry or borrow pulse lasts exactly one clock cycle, and the two pulses are never high together.
- R9: After `modSel` changes, counting continues from the old count masked to the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cntEn | input | 1 | Count enable |
| dirDown | input | 1 | Direction: 1 counts down, 0 counts up |
| modSel | input | 4 | Length code; 0 stops the counter, n selects length 2^(n+2) |
| carryPulse | output | 1 | One-cycle pulse on an upward wrap |
| borrowPulse | output | 1 | One-cycle pulse on a downward wrap |

## Verification
Every result is due one clock cycle after its stimulus. An input set before a rising edge decides that edge's count update, and any carry or borrow pulse from that edge appears at the outputs right after it. The bench changes inputs on falling edges. It then waits for one rising edge and compares both pulse outputs at the next falling edge with a reference count model that was advanced for that same edge. Directed runs cover a full period at the shortest length, a borrow followed by a carry at the longest length, a stop code in the middle of a run, and a length that shrinks in the middle of a period. Random runs cover mixed codes, directions, enables and resets.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic wrapUp;
    logic wrapDown;
  } mlc_strobe_t;
endpackage

// File: rtl/mlc_mask_decode.sv
module mlc_mask_decode #(
  parameter int CNT_W   = 17,
  parameter int SEL_W   = 4,
  parameter int MIN_LOG = 3
) (
  input  logic [SEL_W-1:0] modSel,
  output logic [CNT_W-1:0] lenMask,
  output logic             active
);
  localparam int LEN_W = $clog2(CNT_W + MIN_LOG + (1 << SEL_W)) + 1;

  logic [LEN_W-1:0] lenBits;

  assign active  = (modSel != '0);
  assign lenBits = LEN_W'(modSel) + LEN_W'(MIN_LOG - 1);

  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    assign lenMask[i] = active && (LEN_W'(i) < lenBits);
  end
endmodule

// File: rtl/mlc_datapath.sv
module mlc_datapath
  import mlc_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  mlc_strobe_t      strobes,
  input  logic [CNT_W-1:0] lenMask,
  output logic             atTop,
  output logic             atZero
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] maskedCount;

  assign maskedCount = count & lenMask;
  assign atTop       = (maskedCount == lenMask);
  assign atZero      = (maskedCount == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (strobes.wrapUp) begin
      count <= '0;
    end else if (strobes.wrapDown) begin
      count <= lenMask;
    end else if (strobes.stepUp) begin
      count <= maskedCount + CNT_W'(1);
    end else if (strobes.stepDown) begin
      count <= maskedCount - CNT_W'(1);
    end
  end

  // R5: an upward wrap leaves the count at zero
  p_wrap_up_zero_r5: assert property (@(posedge clk) disable iff (rst)
    strobes.wrapUp |=> (count == '0));

  // R6: a downward wrap leaves the count at the top of the old length
  p_wrap_down_top_r6: assert property (@(posedge clk) disable iff (rst)
    strobes.wrapDown |=> (count == $past(lenMask)));

  // R7: with no strobe the count does not move
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (strobes == '0) |=> $stable(count));
endmodule

// File: rtl/mlc_control.sv
module mlc_control
  import mlc_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cntEn,
  input  logic             dirDown,
  input  logic [SEL_W-1:0] modSel,
  input  logic             active,
  input  logic             atTop,
  input  logic             atZero,
  output mlc_strobe_t      strobes,
  output logic             carryPulse,
  output logic             borrowPulse
);
  logic goUp;
  logic goDown;

  assign goUp   = cntEn && active && !dirDown;
  assign goDown = cntEn && active &&  dirDown;

  always_comb begin
    strobes          = '0;
    strobes.wrapUp   = goUp   &&  atTop;
    strobes.stepUp   = goUp   && !atTop;
    strobes.wrapDown = goDown &&  atZero;
    strobes.stepDown = goDown && !atZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carryPulse  <= 1'b0;
      borrowPulse <= 1'b0;
    end else begin
      carryPulse  <= strobes.wrapUp;
      borrowPulse <= strobes.wrapDown;
    end
  end

  // R8: the two pulses never overlap
  p_excl_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    !(carryPulse && borrowPulse));

  // R8: a carry pulse lasts one cycle
  p_single_carry_r8: assert property (@(posedge clk) disable iff (rst)
    carryPulse |=> !carryPulse);

  // R8: a borrow pulse lasts one cycle
  p_single_borrow_r8: assert property (@(posedge clk) disable iff (rst)
    borrowPulse |=> !borrowPulse);

  // R2: the stop code yields no pulse
  p_inhibit_r2: assert property (@(posedge clk) disable iff (rst)
    (modSel == '0) |=> (!carryPulse && !borrowPulse));

  // R7: enable low yields no pulse
  p_enable_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !cntEn |=> (!carryPulse && !borrowPulse));
endmodule

// File: rtl/modloop_counter.sv
module modloop_counter
  import mlc_pkg::*;
#(
  parameter int CNT_W   = 17,
  parameter int SEL_W   = 4,
  parameter int MIN_LOG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cntEn,
  input  logic             dirDown,
  input  logic [SEL_W-1:0] modSel,
  output logic             carryPulse,
  output logic             borrowPulse
);
  mlc_strobe_t      strobes;
  logic [CNT_W-1:0] lenMask;
  logic             active;
  logic             atTop;
  logic             atZero;

  mlc_mask_decode #(.CNT_W(CNT_W), .SEL_W(SEL_W), .MIN_LOG(MIN_LOG)) u_decode (
    .modSel  (modSel),
    .lenMask (lenMask),
    .active  (active)
  );

  mlc_control #(.SEL_W(SEL_W)) u_control (
    .clk         (clk),
    .rst         (rst),
    .cntEn       (cntEn),
    .dirDown     (dirDown),
    .modSel      (modSel),
    .active      (active),
    .atTop       (atTop),
    .atZero      (atZero),
    .strobes     (strobes),
    .carryPulse  (carryPulse),
    .borrowPulse (borrowPulse)
  );

  mlc_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .lenMask (lenMask),
    .atTop   (atTop),
    .atZero  (atZero)
  );
endmodule

// File: tb/modloop_counter_test.sv
`timescale 1ns/1ps
module modloop_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cntEn = 1'b0;
  logic       dirDown = 1'b0;
  logic [3:0] modSel = 4'd0;
  logic       carryPulse;
  logic       borrowPulse;

  int testsRun = 0;
  int testsFailed = 0;
  bit benchDone = 1'b0;

  logic [16:0] refCount = '0;

  always #10 clk = ~clk;

  modloop_counter uut (
    .clk         (clk),
    .rst         (rst),
    .cntEn       (cntEn),
    .dirDown     (dirDown),
    .modSel      (modSel),
    .carryPulse  (carryPulse),
    .borrowPulse (borrowPulse)
  );

  // Length mask from the length code, per R3 (zero code: empty mask)
  function automatic logic [16:0] maskOf(input logic [3:0] sel);
    logic [16:0] m;
    m = '0;
    for (int i = 0; i < 17; i++)
      if (sel != 4'd0 && i < int'(sel) + 2) m[i] = 1'b1;
    return m;
  endfunction

  task automatic step(input logic r, input logic e, input logic d,
                      input logic [3:0] s, input string tag);
    logic expC;
    logic expB;
    logic [16:0] m;
    logic [16:0] mc;
    rst = r; cntEn = e; dirDown = d; modSel = s;
    expC = 1'b0; expB = 1'b0;
    m  = maskOf(s);
    mc = refCount & m;
    if (r) begin
      refCount = '0;
    end else if (e && s != 4'd0) begin
      if (!d) begin
        if (mc == m) begin refCount = '0; expC = 1'b1; end
        else refCount = mc + 17'd1;
      end else begin
        if (mc == '0) begin refCount = m; expB = 1'b1; end
        else refCount = mc - 17'd1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    testsRun++;
    if (carryPulse !== expC || borrowPulse !== expB) begin
      testsFailed++;
      $display("FAIL %s: carry/borrow actual %b/%b expected %b/%b",
               tag, carryPulse, borrowPulse, expC, expB);
    end
  endtask

  initial begin
    #(20ns * 150000);
    if (!benchDone) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // R1: reset state
    step(1, 0, 0, 4'd0, "R1");
    step(1, 1, 0, 4'd1, "R1");

    // R3: shortest length, 8 up counts then carry (R5)
    for (int i = 0; i < 8; i++) step(0, 1, 0, 4'd1, "R3 R5");
    for (int i = 0; i < 8; i++) step(0, 1, 0, 4'd1, "R3");

    // R3: length 16 and 64
    step(1, 0, 0, 4'd2, "R1");
    for (int i = 0; i < 16; i++) step(0, 1, 0, 4'd2, "R3");
    for (int i = 0; i < 64; i++) step(0, 1, 0, 4'd4, "R3");

    // R6 and R4: borrow from zero at once, then count down
    step(1, 0, 0, 4'd1, "R1");
    step(0, 1, 1, 4'd1, "R6");
    for (int i = 0; i < 9; i++) step(0, 1, 1, 4'd1, "R4 R6");

    // R3 R8: longest length, borrow then immediate carry
    step(1, 0, 0, 4'd15, "R1");
    step(0, 1, 1, 4'd15, "R3 R6");
    step(0, 1, 0, 4'd15, "R3 R5 R8");
    step(0, 1, 0, 4'd15, "R8");

    // R1: reset in the middle of a count
    for (int i = 0; i < 5; i++) step(0, 1, 0, 4'd1, "R1");
    step(1, 1, 0, 4'd1, "R1");
    for (int i = 0; i < 8; i++) step(0, 1, 0, 4'd1, "R1 R3");

    // R2: stop code holds the count
    step(1, 0, 0, 4'd1, "R1");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 4'd1, "R2");
    for (int i = 0; i < 12; i++) step(0, 1, i[0], 4'd0, "R2");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 4'd1, "R2");

    // R7: enable low holds the count
    for (int i = 0; i < 4; i++) step(0, 1, 0, 4'd1, "R7");
    for (int i = 0; i < 10; i++) step(0, 0, i[0], 4'd1, "R7");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 4'd1, "R7");

    // R9: length shrinks mid period (20 masked to 4, carry after 4 more)
    step(1, 0, 0, 4'd4, "R1");
    for (int i = 0; i < 20; i++) step(0, 1, 0, 4'd4, "R9");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 4'd1, "R9");
    for (int i = 0; i < 6; i++) step(0, 1, 1, 4'd1, "R9 R4");

    // Random mix
    begin
      logic dirHold = 1'b0;
      for (int n = 0; n < 6000; n++) begin
        logic [3:0] s;
        if ($urandom % 16 == 0) dirHold = ~dirHold;
        s = ($urandom % 10 == 0) ? 4'($urandom % 16) : 4'(1 + $urandom % 3);
        step(($urandom % 700) == 0, ($urandom % 8) != 0, dirHold, s,
             "R4 R5 R6 R8 R9");
      end
    end

    benchDone = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule